// File: doc/BRIEF.md
# I2C Receive Acknowledge Controller

This block works next to an I2C byte engine and settles the level put on the data line in the acknowledge slot of every received byte. It serves both master and slave receivers. A level of 0 means ACK (data line pulled low) and a level of 1 means NACK (data line released). The block has two acknowledge modes. In the deferred mode, software writes the acknowledge choice ahead of time, and that choice is picked up when the next byte begins. In the immediate mode, the block holds the serial clock low once the eighth bit of a received byte is in. It keeps holding until software writes the choice for that same byte.

The block also does three other jobs. It turns completed-byte and address-match events into single-cycle DMA requests, and which events count depends on the acknowledge mode. It keeps the addressed-as-slave and transfer-complete flags and drives a wake-up output while in low-power mode. It turns repeated-START writes into a one-cycle request to the engine, or into an arbitration-loss pulse when the request comes at an illegal point. Bit-level line sequencing and arbitration stay in the byte engine.

All control fields are loaded together by one write strobe (`wr_ctrl`) with one data input per field. Event inputs from the engine are single-cycle strobes.

Top module: `i2c_rx_ack_ctrl`

## Requirements
- R1: After reset, `ack_level` equals the RESET_NACK parameter (default 0), and `scl_hold`, `dma_req`, `tcf`, `iaas`, `wake`, `rsta_req`, `arb_lost` and `rd_nack` are all 0.
- R2: With the immediate mode bit clear, a written acknowledge value (0 = ACK, 1 = NACK) does not change `ack_level` during the current byte. `ack_level` takes the stored value in the cycle after `byte_start`.
- R3: With the immediate mode bit set, `bits8_done` on a received byte (`xfer_tx` = 0) raises `scl_hold` in the next cycle. It stays high until a `wr_ctrl` write. In the cycle after that write, `scl_hold` is 0 and `ack_level` equals the written `wr_nack`.
- R4: `bits8_done` on a transmitted byte (`xfer_tx` = 1) never raises `scl_hold`.
- R5: A write with `wr_rsta` = 1 while `is_master` = 1 and `rsta_legal` = 1 makes `rsta_req` high for exactly the one cycle after the write. `rd_rsta` always reads 0.
- R6: A repeated-START write while master with `rsta_legal` = 0 gives a one-cycle `arb_lost` and no `rsta_req`. When not master, the write gives neither.
- R7: With DMA enabled and the immediate mode bit clear, `dma_req` pulses in the cycle after `byte_done` in three cases: a received data byte, any transmitted byte, or a received address byte with `addr_match` or `gen_call`. A received address byte with no match gives no pulse.
- R8: With DMA enabled and the immediate mode bit set, only transmitted bytes (`xfer_tx` = 1) give a `dma_req` pulse.
- R9: With DMA disabled there is never a `dma_req`. Every pulse lasts exactly one cycle.
- R10: `byte_done` sets `tcf` in the next cycle, and `byte_start` clears it. A received address byte that matches sets `iaas` and `tcf` together.
- R11: `iaas` clears after `stop_det`, or after a received address byte without a match.
- R12: With the wake enable bit set and `low_power` = 1, an address match sets `wake`, which falls in the cycle after `low_power` drops. With the wake enable bit clear, a match never sets `wake`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_ctrl | input | 1 | Control write strobe; loads all fields below |
| wr_nack | input | 1 | Acknowledge choice, 0 = ACK, 1 = NACK |
| wr_fast | input | 1 | Immediate acknowledge mode bit |
| wr_dma_en | input | 1 | DMA enable bit |
| wr_wake_en | input | 1 | Wake-up enable bit |
| wr_rsta | input | 1 | Repeated-START request bit |
| is_master | input | 1 | Block currently owns the bus |
| rsta_legal | input | 1 | Engine can issue a repeated START now |
| byte_start | input | 1 | Strobe: a new byte begins |
| bits8_done | input | 1 | Strobe: eighth data bit finished |
| byte_done | input | 1 | Strobe: byte including acknowledge finished |
| xfer_tx | input | 1 | Direction of current byte, 1 = transmit |
| addr_phase | input | 1 | Current byte is an address byte |
| addr_match | input | 1 | Address byte matched own slave address |
| gen_call | input | 1 | Address byte is the general-call address |
| stop_det | input | 1 | Strobe: STOP condition seen |
| low_power | input | 1 | System is in low-power mode |
| ack_level | output | 1 | Level driven in the acknowledge slot |
| scl_hold | output | 1 | Request to hold the serial clock low |
| dma_req | output | 1 | Single-cycle DMA request |
| tcf | output | 1 | Transfer-complete flag |
| iaas | output | 1 | Addressed-as-slave flag |
| wake | output | 1 | Wake-up request |
| rsta_req | output | 1 | One-cycle repeated-START request to the engine |
| arb_lost | output | 1 | One-cycle loss-of-arbitration report |
| rd_nack | output | 1 | Readback of stored acknowledge choice |
| rd_rsta | output | 1 | Readback of repeated-START bit, always 0 |

## Verification
The most serious state fault is a held clock that is not released, or released without cause. It would freeze the bus or acknowledge with a stale level. `scl_hold` and `ack_level` expose it in the cycle after `wr_ctrl`.

A latch of the acknowledge choice at the wrong moment shows up as `ack_level` changing in mid-byte, or failing to change one cycle after `byte_start`. Event flags that decode the wrong case show up as `dma_req`, `tcf` or `iaas` wrong in the single cycle after `byte_done`. The vector table walks every mode, direction and match combination for that reason.

// File: rtl/i2c_ack_pkg.sv
package i2c_ack_pkg;

    typedef struct packed {
        logic nack;
        logic fast;
        logic dma_en;
        logic wake_en;
        logic ack_lvl;
        logic hold;
    } ack_st_t;

    typedef struct packed {
        logic dma;
        logic tcf;
        logic iaas;
        logic wake;
    } evt_st_t;

    typedef struct packed {
        logic req;
        logic lost;
    } rsta_st_t;

endpackage

// File: rtl/ack_ctl.sv
module ack_ctl
    import i2c_ack_pkg::*;
#(
    parameter logic RESET_NACK = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_ctrl,
    input  logic wr_nack,
    input  logic wr_fast,
    input  logic wr_dma_en,
    input  logic wr_wake_en,
    input  logic byte_start,
    input  logic bits8_done,
    input  logic xfer_tx,
    output logic ack_level,
    output logic scl_hold,
    output logic fast_mode,
    output logic dma_en,
    output logic wake_en,
    output logic nack_bit
);

    ack_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // deferred mode: stored choice takes effect as a byte begins
        if (byte_start && !st_q.fast)
            st_d.ack_lvl = st_q.nack;
        // immediate mode: stretch clock after eighth bit of a received byte
        if (bits8_done && st_q.fast && !xfer_tx)
            st_d.hold = 1'b1;
        if (wr_ctrl) begin
            st_d.nack    = wr_nack;
            st_d.fast    = wr_fast;
            st_d.dma_en  = wr_dma_en;
            st_d.wake_en = wr_wake_en;
            st_d.hold    = 1'b0;
            if (wr_fast)
                st_d.ack_lvl = wr_nack;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.nack    <= RESET_NACK;
            st_q.fast    <= 1'b0;
            st_q.dma_en  <= 1'b0;
            st_q.wake_en <= 1'b0;
            st_q.ack_lvl <= RESET_NACK;
            st_q.hold    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ack_level = st_q.ack_lvl;
    assign scl_hold  = st_q.hold;
    assign fast_mode = st_q.fast;
    assign dma_en    = st_q.dma_en;
    assign wake_en   = st_q.wake_en;
    assign nack_bit  = st_q.nack;

endmodule

// File: rtl/evt_flags.sv
module evt_flags
    import i2c_ack_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic byte_start,
    input  logic byte_done,
    input  logic xfer_tx,
    input  logic addr_phase,
    input  logic addr_match,
    input  logic gen_call,
    input  logic stop_det,
    input  logic low_power,
    input  logic fast_mode,
    input  logic dma_en,
    input  logic wake_en,
    output logic dma_req,
    output logic tcf,
    output logic iaas,
    output logic wake
);

    evt_st_t st_d, st_q;
    logic    rx_addr, hit_ev, miss_ev, dma_ev;

    always_comb begin
        rx_addr = byte_done && addr_phase && !xfer_tx;
        hit_ev  = rx_addr && (addr_match || gen_call);
        miss_ev = rx_addr && !(addr_match || gen_call);
        if (fast_mode)
            dma_ev = byte_done && xfer_tx;
        else
            dma_ev = byte_done && (xfer_tx || !addr_phase || addr_match || gen_call);

        st_d     = st_q;
        st_d.dma = dma_en && dma_ev && !st_q.dma;

        if (byte_start)
            st_d.tcf = 1'b0;
        if (byte_done)
            st_d.tcf = 1'b1;

        if (hit_ev)
            st_d.iaas = 1'b1;
        else if (stop_det || miss_ev)
            st_d.iaas = 1'b0;

        if (!low_power)
            st_d.wake = 1'b0;
        else if (hit_ev && wake_en)
            st_d.wake = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign dma_req = st_q.dma;
    assign tcf     = st_q.tcf;
    assign iaas    = st_q.iaas;
    assign wake    = st_q.wake;

endmodule

// File: rtl/rsta_gen.sv
module rsta_gen
    import i2c_ack_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_ctrl,
    input  logic wr_rsta,
    input  logic is_master,
    input  logic rsta_legal,
    output logic rsta_req,
    output logic arb_lost
);

    rsta_st_t st_d, st_q;
    logic     ask;

    always_comb begin
        ask       = wr_ctrl && wr_rsta && is_master;
        st_d.req  = ask && rsta_legal;
        st_d.lost = ask && !rsta_legal;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign rsta_req = st_q.req;
    assign arb_lost = st_q.lost;

endmodule

// File: rtl/i2c_rx_ack_ctrl.sv
module i2c_rx_ack_ctrl #(
    parameter logic RESET_NACK = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_ctrl,
    input  logic wr_nack,
    input  logic wr_fast,
    input  logic wr_dma_en,
    input  logic wr_wake_en,
    input  logic wr_rsta,
    input  logic is_master,
    input  logic rsta_legal,
    input  logic byte_start,
    input  logic bits8_done,
    input  logic byte_done,
    input  logic xfer_tx,
    input  logic addr_phase,
    input  logic addr_match,
    input  logic gen_call,
    input  logic stop_det,
    input  logic low_power,
    output logic ack_level,
    output logic scl_hold,
    output logic dma_req,
    output logic tcf,
    output logic iaas,
    output logic wake,
    output logic rsta_req,
    output logic arb_lost,
    output logic rd_nack,
    output logic rd_rsta
);

    logic fast_mode, dma_en, wake_en;

    ack_ctl #(.RESET_NACK(RESET_NACK)) u_ack (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_ctrl    (wr_ctrl),
        .wr_nack    (wr_nack),
        .wr_fast    (wr_fast),
        .wr_dma_en  (wr_dma_en),
        .wr_wake_en (wr_wake_en),
        .byte_start (byte_start),
        .bits8_done (bits8_done),
        .xfer_tx    (xfer_tx),
        .ack_level  (ack_level),
        .scl_hold   (scl_hold),
        .fast_mode  (fast_mode),
        .dma_en     (dma_en),
        .wake_en    (wake_en),
        .nack_bit   (rd_nack)
    );

    evt_flags u_evt (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_start (byte_start),
        .byte_done  (byte_done),
        .xfer_tx    (xfer_tx),
        .addr_phase (addr_phase),
        .addr_match (addr_match),
        .gen_call   (gen_call),
        .stop_det   (stop_det),
        .low_power  (low_power),
        .fast_mode  (fast_mode),
        .dma_en     (dma_en),
        .wake_en    (wake_en),
        .dma_req    (dma_req),
        .tcf        (tcf),
        .iaas       (iaas),
        .wake       (wake)
    );

    rsta_gen u_rsta (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_ctrl    (wr_ctrl),
        .wr_rsta    (wr_rsta),
        .is_master  (is_master),
        .rsta_legal (rsta_legal),
        .rsta_req   (rsta_req),
        .arb_lost   (arb_lost)
    );

    // the repeated-START bit is write-only
    assign rd_rsta = 1'b0;

endmodule

// File: rtl/i2c_rx_ack_ctrl_chk.sv
module i2c_rx_ack_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_ctrl,
    input logic scl_hold,
    input logic rsta_req,
    input logic arb_lost,
    input logic is_master,
    input logic dma_req,
    input logic byte_done,
    input logic iaas,
    input logic tcf,
    input logic wake,
    input logic low_power
);

    assert_hold_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_hold && wr_ctrl) |=> !scl_hold);

    assert_rsta_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsta_req |=> !rsta_req);

    assert_rsta_master_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsta_req |-> $past(is_master));

    assert_rsta_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsta_req && arb_lost));

    assert_dma_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> $past(byte_done));

    assert_dma_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |=> !dma_req);

    assert_match_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(iaas) |-> tcf);

    assert_wake_lp_R12: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> $past(low_power));

endmodule

bind i2c_rx_ack_ctrl i2c_rx_ack_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_ctrl   (wr_ctrl),
    .scl_hold  (scl_hold),
    .rsta_req  (rsta_req),
    .arb_lost  (arb_lost),
    .is_master (is_master),
    .dma_req   (dma_req),
    .byte_done (byte_done),
    .iaas      (iaas),
    .tcf       (tcf),
    .wake      (wake),
    .low_power (low_power)
);

// File: tb/sim_i2c_rx_ack_ctrl.sv
`timescale 1ns/1ps
module sim_i2c_rx_ack_ctrl;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_ctrl = 0, wr_nack = 0, wr_fast = 0, wr_dma_en = 0, wr_wake_en = 0, wr_rsta = 0;
    logic is_master = 0, rsta_legal = 0;
    logic byte_start = 0, bits8_done = 0, byte_done = 0;
    logic xfer_tx = 0, addr_phase = 0, addr_match = 0, gen_call = 0;
    logic stop_det = 0, low_power = 0;
    logic ack_level, scl_hold, dma_req, tcf, iaas, wake, rsta_req, arb_lost, rd_nack, rd_rsta;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    i2c_rx_ack_ctrl u0 (.*);

    // [7]=fast [6]=dma_en [5]=tx [4]=addr [3]=match [2]=gencall [1]=exp dma [0]=exp iaas
    localparam logic [7:0] VEC [10] = '{
        8'b0100_0010, // R7 received data byte
        8'b0110_0010, // R7 transmitted data byte
        8'b0111_0010, // R7 transmitted address byte
        8'b0101_1011, // R7 received address match
        8'b0101_0111, // R7 received general call
        8'b0101_0000, // R7 received address miss
        8'b1100_0000, // R8 received data byte, immediate mode
        8'b1110_0010, // R8 transmitted byte, immediate mode
        8'b1101_1001, // R8 received address match, immediate mode
        8'b0010_0000  // R9 DMA disabled
    };

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic wr(input logic n, input logic f, input logic d, input logic w, input logic r);
        wr_ctrl = 1; wr_nack = n; wr_fast = f; wr_dma_en = d; wr_wake_en = w; wr_rsta = r;
        step();
        wr_ctrl = 0; wr_rsta = 0;
    endtask

    task automatic pulse_start();  byte_start = 1; step(); byte_start = 0; endtask
    task automatic pulse_bits8();  bits8_done = 1; step(); bits8_done = 0; endtask
    task automatic pulse_done();   byte_done  = 1; step(); byte_done  = 0; endtask
    task automatic pulse_stop();   stop_det   = 1; step(); stop_det   = 0; endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        // R1 reset state
        chk("R1 ack_level", ack_level, 1'b0);
        chk("R1 scl_hold", scl_hold, 1'b0);
        chk("R1 dma_req", dma_req, 1'b0);
        chk("R1 tcf", tcf, 1'b0);
        chk("R1 iaas", iaas, 1'b0);
        chk("R1 wake", wake, 1'b0);
        chk("R1 rsta_req", rsta_req | arb_lost, 1'b0);
        chk("R1 rd_nack", rd_nack, 1'b0);
        rst_n = 1;
        step();

        // vector table
        for (int i = 0; i < 10; i++) begin
            wr(1'b0, VEC[i][7], VEC[i][6], 1'b0, 1'b0);
            pulse_stop();
            xfer_tx = VEC[i][5]; addr_phase = VEC[i][4];
            addr_match = VEC[i][3]; gen_call = VEC[i][2];
            pulse_done();
            chk($sformatf("R7/R8 dma vec%0d", i), dma_req, VEC[i][1]);
            chk($sformatf("R10 iaas vec%0d", i), iaas, VEC[i][0]);
            chk($sformatf("R10 tcf vec%0d", i), tcf, 1'b1);
            addr_match = 0; gen_call = 0; addr_phase = 0; xfer_tx = 0;
            step();
            chk($sformatf("R9 dma single vec%0d", i), dma_req, 1'b0);
        end

        // R10 tcf cleared by next byte start
        pulse_start();
        chk("R10 tcf clear", tcf, 1'b0);

        // R2 deferred acknowledge
        wr(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R2 rd_nack", rd_nack, 1'b1);
        chk("R2 no mid-byte change", ack_level, 1'b0);
        pulse_start();
        chk("R2 applied at next byte", ack_level, 1'b1);
        wr(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R2 held during byte", ack_level, 1'b1);
        pulse_bits8();
        chk("R2 no hold in deferred mode", scl_hold, 1'b0);
        pulse_start();
        chk("R2 ACK at next byte", ack_level, 1'b0);

        // R3 immediate acknowledge with clock stretch
        wr(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        xfer_tx = 0;
        pulse_bits8();
        chk("R3 hold raised", scl_hold, 1'b1);
        step(); step(); step();
        chk("R3 hold kept", scl_hold, 1'b1);
        chk("R3 level before write", ack_level, 1'b0);
        wr(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R3 hold released", scl_hold, 1'b0);
        chk("R3 NACK driven", ack_level, 1'b1);

        // R4 transmit byte never stretches
        xfer_tx = 1;
        pulse_bits8();
        chk("R4 no hold on tx", scl_hold, 1'b0);
        xfer_tx = 0;

        // R5 legal repeated START
        is_master = 1; rsta_legal = 1;
        wr(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R5 rsta_req", rsta_req, 1'b1);
        chk("R5 rd_rsta", rd_rsta, 1'b0);
        chk("R6 no arb_lost", arb_lost, 1'b0);
        step();
        chk("R5 one cycle", rsta_req, 1'b0);

        // R6 illegal point and not master
        rsta_legal = 0;
        wr(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R6 arb_lost", arb_lost, 1'b1);
        chk("R6 no rsta_req", rsta_req, 1'b0);
        step();
        chk("R6 arb_lost one cycle", arb_lost, 1'b0);
        is_master = 0; rsta_legal = 1;
        wr(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R6 slave ignores rsta", rsta_req | arb_lost, 1'b0);

        // R11 iaas clearing
        addr_phase = 1; addr_match = 1;
        pulse_done();
        chk("R11 iaas set", iaas, 1'b1);
        addr_match = 0; addr_phase = 0;
        pulse_stop();
        chk("R11 cleared by stop", iaas, 1'b0);
        addr_phase = 1; addr_match = 1;
        pulse_done();
        addr_match = 0;
        pulse_done();
        chk("R11 cleared by miss", iaas, 1'b0);
        addr_phase = 0;

        // R12 wake-up
        wr(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        low_power = 1; addr_phase = 1; addr_match = 1;
        pulse_done();
        chk("R12 wake set", wake, 1'b1);
        low_power = 0;
        step();
        chk("R12 wake cleared", wake, 1'b0);
        wr(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        low_power = 1;
        pulse_done();
        chk("R12 no wake when disabled", wake, 1'b0);
        low_power = 0; addr_phase = 0; addr_match = 0;
        step();

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule